// File: doc/BRIEF.md
# Host Mailbox Port

The block is a parallel port that lets an external host processor exchange 16-bit words with a processor core through six mailbox registers. The host's lines run on their own timing. Every host line, including the data and address buses, passes through a two-flop synchroniser into the core clock domain. A transfer takes effect once, at the trailing edge of its strobe. The core sees the same mailboxes, a status word, a control word and an interrupt mask as ordinary registers on a simple synchronous bus.

The port records, for each mailbox, whether the host has written it and whether the host has read it. The core can poll these flags. It can also take one-cycle interrupt pulses, which are gated per mailbox and per direction and by a global enable for each direction.

Three static strap inputs set the host protocol:
- 8-bit or 16-bit transfers.
- Separate read and write strobes, or a data strobe with a direction line.
- A separate 3-bit address bus, or an address carried on the data bus and captured by an address latch enable.

A soft-reset bit can be set from either side. It clears the mailbox contents and the flags.

Top module: `hmb_port`

## Requirements
- R1: After the synchronous reset, every mailbox, the status word (core address 6), the control word (core address 7) and the mask word (core address 8) read 0, and both interrupt outputs are low.
- R2: A 16-bit host write to host address i (0 to 5) stores the word. The core then reads it at core address i, and bit i of the status word is set.
- R3: A completed host read of mailbox i sets bit 8+i of the status word.
- R4: A core read of mailbox i clears status bit i. A core write of mailbox i clears status bit 8+i and changes the value the host reads back.
- R5: Each completed host write to mailbox i gives exactly one one-cycle pulse on `irq_wr`, but only when mask bit i (mask word bits 5:0) and the write enable (control bit 1) are both 1. Otherwise it gives none, and the status flag is still set.
- R6: Each completed host read of mailbox i gives exactly one one-cycle pulse on `irq_rd`, but only when mask bit 8+i and the read enable (control bit 2) are both 1.
- R7: With `strap_byte`=1, a host write is two transfers on bus bits 7:0, low byte first, and bus bits 15:8 are ignored. The mailbox, its flag and its interrupt change only after the second transfer.
- R8: With `strap_byte`=1, a host read is two transfers that return the low byte and then the high byte on `h_dout` bits 7:0, with bits 15:8 zero. The read flag is set only after the second transfer.
- R9: With `strap_rwds`=1, `h_rd_n` is an active-low data strobe and `h_wr_n` gives the direction (1 = read, 0 = write).
- R10: With `strap_mux`=1, the register address is taken from `h_din` bits 2:0 at the falling edge of `h_ale`, and the data uses the same bus.
- R11: A host write to address 7 with data bit 0 set, or a core write to control bit 0, clears all mailboxes, all status flags and the byte phase. The bit then reads 0, and the enables and mask keep their values. A host write to address 7 with bit 0 clear changes nothing.
- R12: A host write to address 6 (status) has no effect on any register and raises no interrupt. A host read of address 6 returns the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_byte | input | 1 | 1 = 8-bit host transfers |
| strap_rwds | input | 1 | 1 = data strobe plus direction line |
| strap_mux | input | 1 | 1 = address multiplexed on data bus |
| h_rd_n | input | 1 | Read strobe, or data strobe when strap_rwds=1 (active low) |
| h_wr_n | input | 1 | Write strobe, or direction (1 = read) when strap_rwds=1 |
| h_ale | input | 1 | Address latch enable (multiplexed mode) |
| h_addr | input | 3 | Host register address (separate-bus mode) |
| h_din | input | 16 | Host data in, also address in multiplexed mode |
| h_dout | output | 16 | Host read data |
| c_addr | input | 4 | Core register address |
| c_wr | input | 1 | Core write strobe |
| c_rd | input | 1 | Core read strobe |
| c_wdata | input | 16 | Core write data |
| c_rdata | output | 16 | Core read data |
| irq_wr | output | 1 | Host-write interrupt pulse |
| irq_rd | output | 1 | Host-read interrupt pulse |

## Verification
The bench runs all eight strap combinations over all six mailboxes and checks that data, flags and interrupt counts match in both directions.

It stops an 8-bit transfer after its first byte to confirm that nothing is committed early. A design that committed the low byte at once would raise a flag and an interrupt too soon, and would store a half word.

It sweeps every combination of mask bit and global enable. A design that took either input alone would fire interrupts where none are due.

It also covers these cases:
- Soft reset from each side, including one given in the middle of a byte pair, where a phase that was not cleared would leave every later word with its bytes swapped.
- A host write to address 7 with bit 0 clear, which must reset nothing.
- Host writes to the read-only status address, which a loose decoder would turn into flag corruption.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
    localparam int NREG   = 6;
    localparam int DW     = 16;
    localparam int BW     = DW / 2;
    localparam int HAW    = 3;
    localparam int CAW    = 4;
    localparam int RFLAG0 = DW / 2;

    localparam logic [HAW-1:0] HA_STAT = HAW'(6);
    localparam logic [HAW-1:0] HA_CTL  = HAW'(7);
    localparam logic [CAW-1:0] CA_STAT = CAW'(6);
    localparam logic [CAW-1:0] CA_CTL  = CAW'(7);
    localparam logic [CAW-1:0] CA_MASK = CAW'(8);

    localparam int CTL_SRST = 0;
    localparam int CTL_WEN  = 1;
    localparam int CTL_REN  = 2;

    typedef struct packed {
        logic           wr;
        logic           rd;
        logic [HAW-1:0] addr;
        logic [DW-1:0]  data;
    } hevt_t;

    function automatic logic [DW-1:0] pair_word(logic [NREG-1:0] lo, logic [NREG-1:0] hi);
        logic [DW-1:0] w;
        w = '0;
        w[NREG-1:0]          = lo;
        w[RFLAG0 +: NREG]    = hi;
        return w;
    endfunction

    function automatic logic [DW-1:0] ctl_word(logic ren, logic wen, logic srst);
        logic [DW-1:0] w;
        w = '0;
        w[CTL_REN]  = ren;
        w[CTL_WEN]  = wen;
        w[CTL_SRST] = srst;
        return w;
    endfunction
endpackage

// File: rtl/hmb_sync.sv
module hmb_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hmb_host_front.sv
module hmb_host_front
    import hmb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           strap_byte,
    input  logic           strap_rwds,
    input  logic           strap_mux,
    input  logic           h_rd_n,
    input  logic           h_wr_n,
    input  logic           h_ale,
    input  logic [HAW-1:0] h_addr,
    input  logic [DW-1:0]  h_din,
    output hevt_t          evt,
    output logic [HAW-1:0] cur_addr,
    output logic           cur_hi
);
    localparam int            SW   = 3 + HAW + DW;
    localparam logic [SW-1:0] SRST = {2'b11, {(SW-2){1'b0}}};

    logic [SW-1:0]  s;
    logic           rd_n_s, wr_n_s, ale_s;
    logic [HAW-1:0] addr_s;
    logic [DW-1:0]  din_s;
    logic           rd_act, wr_act, rd_q, wr_q, ale_q;
    logic           rd_end, wr_end;
    logic [HAW-1:0] lat_addr;
    logic           phase;
    logic [BW-1:0]  lo_byte;

    hmb_sync #(.W(SW), .RST_VAL(SRST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({h_rd_n, h_wr_n, h_ale, h_addr, h_din}),
        .q   (s)
    );

    assign rd_n_s = s[SW-1];
    assign wr_n_s = s[SW-2];
    assign ale_s  = s[SW-3];
    assign addr_s = s[DW +: HAW];
    assign din_s  = s[DW-1:0];

    // strobe style decode
    assign rd_act = strap_rwds ? (~rd_n_s &  wr_n_s) : ~rd_n_s;
    assign wr_act = strap_rwds ? (~rd_n_s & ~wr_n_s) : ~wr_n_s;
    assign rd_end = rd_q & ~rd_act;
    assign wr_end = wr_q & ~wr_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= 1'b0;
            wr_q     <= 1'b0;
            ale_q    <= 1'b0;
            lat_addr <= '0;
            phase    <= 1'b0;
            lo_byte  <= '0;
        end else begin
            rd_q  <= rd_act;
            wr_q  <= wr_act;
            ale_q <= ale_s;
            if (ale_q && !ale_s)
                lat_addr <= din_s[HAW-1:0];
            if (clr)
                phase <= 1'b0;
            else if (strap_byte && (rd_end || wr_end))
                phase <= ~phase;
            if (strap_byte && wr_end && !phase)
                lo_byte <= din_s[BW-1:0];
        end
    end

    assign cur_addr  = strap_mux ? lat_addr : addr_s;
    assign cur_hi    = strap_byte & phase;
    assign evt.wr    = wr_end & (~strap_byte | phase);
    assign evt.rd    = rd_end & (~strap_byte | phase);
    assign evt.addr  = cur_addr;
    assign evt.data  = strap_byte ? {din_s[BW-1:0], lo_byte} : din_s;

    AST_BYTE_PAIR_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (evt.wr && strap_byte) |=> !phase); // R7
    AST_BYTE_READ_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (evt.rd && strap_byte) |=> !phase); // R8
endmodule

// File: rtl/hmb_irq.sv
module hmb_irq
    import hmb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            blank,
    input  hevt_t           evt,
    input  logic [NREG-1:0] mask_w,
    input  logic [NREG-1:0] mask_r,
    input  logic            wen,
    input  logic            ren,
    output logic            irq_wr,
    output logic            irq_rd
);
    logic [NREG-1:0] hit_w, hit_r;

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign hit_w[g] = evt.wr && (evt.addr == HAW'(g)) && mask_w[g];
        assign hit_r[g] = evt.rd && (evt.addr == HAW'(g)) && mask_r[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_wr <= 1'b0;
            irq_rd <= 1'b0;
        end else begin
            irq_wr <= ~blank & wen & (|hit_w);
            irq_rd <= ~blank & ren & (|hit_r);
        end
    end

    AST_IRQ_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_wr |=> !irq_wr); // R5
    AST_IRQ_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_rd |=> !irq_rd); // R6
endmodule

// File: rtl/hmb_port.sv
module hmb_port
    import hmb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_byte,
    input  logic        strap_rwds,
    input  logic        strap_mux,
    input  logic        h_rd_n,
    input  logic        h_wr_n,
    input  logic        h_ale,
    input  logic [2:0]  h_addr,
    input  logic [15:0] h_din,
    output logic [15:0] h_dout,
    input  logic [3:0]  c_addr,
    input  logic        c_wr,
    input  logic        c_rd,
    input  logic [15:0] c_wdata,
    output logic [15:0] c_rdata,
    output logic        irq_wr,
    output logic        irq_rd
);
    logic [DW-1:0]   mbox [NREG];
    logic [NREG-1:0] wflag, rflag, mask_w, mask_r;
    logic            wen, ren, srst;
    hevt_t           evt;
    logic [HAW-1:0]  cur_addr;
    logic            cur_hi;
    logic [DW-1:0]   stat_w, host_sel;
    logic            c_is_mb, h_is_mb, e_is_mb;
    logic [HAW-1:0]  c_idx;

    hmb_host_front u_front (
        .clk        (clk),
        .rst        (rst),
        .clr        (srst),
        .strap_byte (strap_byte),
        .strap_rwds (strap_rwds),
        .strap_mux  (strap_mux),
        .h_rd_n     (h_rd_n),
        .h_wr_n     (h_wr_n),
        .h_ale      (h_ale),
        .h_addr     (h_addr),
        .h_din      (h_din),
        .evt        (evt),
        .cur_addr   (cur_addr),
        .cur_hi     (cur_hi)
    );

    hmb_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .blank  (srst),
        .evt    (evt),
        .mask_w (mask_w),
        .mask_r (mask_r),
        .wen    (wen),
        .ren    (ren),
        .irq_wr (irq_wr),
        .irq_rd (irq_rd)
    );

    assign c_idx   = c_addr[HAW-1:0];
    assign c_is_mb = c_addr < CAW'(NREG);
    assign h_is_mb = cur_addr < HAW'(NREG);
    assign e_is_mb = evt.addr < HAW'(NREG);
    assign stat_w  = pair_word(wflag, rflag);

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            for (int k = 0; k < NREG; k++) mbox[k] <= '0;
            wflag <= '0;
            rflag <= '0;
            srst  <= 1'b0;
            if (rst) begin
                mask_w <= '0;
                mask_r <= '0;
                wen    <= 1'b0;
                ren    <= 1'b0;
            end
        end else begin
            // core side first; host events below take precedence
            if (c_wr) begin
                if (c_is_mb) begin
                    mbox[c_idx]  <= c_wdata;
                    rflag[c_idx] <= 1'b0;
                end else if (c_addr == CA_CTL) begin
                    ren  <= c_wdata[CTL_REN];
                    wen  <= c_wdata[CTL_WEN];
                    srst <= c_wdata[CTL_SRST];
                end else if (c_addr == CA_MASK) begin
                    mask_w <= c_wdata[NREG-1:0];
                    mask_r <= c_wdata[RFLAG0 +: NREG];
                end
            end
            if (c_rd && c_is_mb)
                wflag[c_idx] <= 1'b0;
            if (evt.wr) begin
                if (e_is_mb) begin
                    mbox[evt.addr]  <= evt.data;
                    wflag[evt.addr] <= 1'b1;
                end else if (evt.addr == HA_CTL && evt.data[CTL_SRST]) begin
                    srst <= 1'b1;
                end
            end
            if (evt.rd && e_is_mb)
                rflag[evt.addr] <= 1'b1;
        end
    end

    always_comb begin
        c_rdata = '0;
        if (c_is_mb)
            c_rdata = mbox[c_idx];
        else if (c_addr == CA_STAT)
            c_rdata = stat_w;
        else if (c_addr == CA_CTL)
            c_rdata = ctl_word(ren, wen, srst);
        else if (c_addr == CA_MASK)
            c_rdata = pair_word(mask_w, mask_r);
    end

    always_comb begin
        if (h_is_mb)
            host_sel = mbox[cur_addr];
        else if (cur_addr == HA_STAT)
            host_sel = stat_w;
        else
            host_sel = ctl_word(ren, wen, srst);
        if (strap_byte)
            h_dout = {{BW{1'b0}}, cur_hi ? host_sel[DW-1:BW] : host_sel[BW-1:0]};
        else
            h_dout = host_sel;
    end

    AST_WR_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_wr |-> (|wflag)); // R5
    AST_RD_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_rd |-> (|rflag)); // R6
    AST_SRST_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $past(srst) |-> (wflag == '0 && rflag == '0)); // R11
    AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        srst |=> !srst); // R11
endmodule

// File: tb/hmb_port_bench.sv
module hmb_port_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        s_byte, s_rwds, s_mux;
    logic        h_rd_n, h_wr_n, h_ale;
    logic [2:0]  h_addr;
    logic [15:0] h_din, h_dout;
    logic [3:0]  c_addr;
    logic        c_wr, c_rd;
    logic [15:0] c_wdata, c_rdata;
    logic        irq_wr, irq_rd;

    int n_chk = 0;
    int n_fail = 0;
    int cnt_w = 0;
    int cnt_r = 0;

    always #5 clk = ~clk;

    hmb_port u_hmb_port (
        .clk(clk), .rst(rst),
        .strap_byte(s_byte), .strap_rwds(s_rwds), .strap_mux(s_mux),
        .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_ale(h_ale), .h_addr(h_addr),
        .h_din(h_din), .h_dout(h_dout),
        .c_addr(c_addr), .c_wr(c_wr), .c_rd(c_rd), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .irq_wr(irq_wr), .irq_rd(irq_rd)
    );

    always @(negedge clk) begin
        if (!rst && irq_wr) cnt_w++;
        if (!rst && irq_rd) cnt_r++;
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic core_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        c_addr = a; c_wdata = d; c_wr = 1'b1;
        @(negedge clk);
        c_wr = 1'b0;
    endtask

    task automatic core_rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        c_addr = a; c_rd = 1'b1;
        #1 d = c_rdata;
        @(negedge clk);
        c_rd = 1'b0;
    endtask

    task automatic host_set_addr(input logic [2:0] a);
        if (s_mux) begin
            @(negedge clk);
            h_din = {13'h0, a}; h_ale = 1'b1;
            wait_clk(4);
            h_ale = 1'b0;
            wait_clk(4);
        end else begin
            h_addr = a;
        end
    endtask

    task automatic host_beat(input bit is_wr, input logic [15:0] d, output logic [15:0] q);
        @(negedge clk);
        if (is_wr) h_din = d;
        if (s_rwds) begin
            h_wr_n = is_wr ? 1'b0 : 1'b1;
            wait_clk(1);
            h_rd_n = 1'b0;
        end else if (is_wr) begin
            h_wr_n = 1'b0;
        end else begin
            h_rd_n = 1'b0;
        end
        wait_clk(6);
        q = h_dout;
        h_rd_n = 1'b1;
        if (!s_rwds) h_wr_n = 1'b1;
        wait_clk(6);
        h_wr_n = 1'b1;
    endtask

    task automatic host_xfer(input bit is_wr, input logic [2:0] a, input logic [15:0] d,
                             input string tag, output logic [15:0] q);
        logic [15:0] q1, q2;
        host_set_addr(a);
        if (s_byte) begin
            host_beat(is_wr, {8'hA5, d[7:0]}, q1);
            host_beat(is_wr, {8'h5A, d[15:8]}, q2);
            if (!is_wr) begin
                check({tag, " upper byte zero"}, {8'h00, q1[15:8]}, 16'h0);
                check({tag, " upper byte zero"}, {8'h00, q2[15:8]}, 16'h0);
            end
            q = {q2[7:0], q1[7:0]};
        end else begin
            host_beat(is_wr, d, q);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] q, s, v;
        int w0, r0;
        string tw, tr;
        rst = 1'b1;
        s_byte = 0; s_rwds = 0; s_mux = 0;
        h_rd_n = 1; h_wr_n = 1; h_ale = 0; h_addr = 0; h_din = 0;
        c_addr = 0; c_wr = 0; c_rd = 0; c_wdata = 0;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);

        // R1 reset state
        check("R1 irq_wr low", {15'h0, irq_wr}, 16'h0);
        check("R1 irq_rd low", {15'h0, irq_rd}, 16'h0);
        check("R1 h_dout", h_dout, 16'h0);
        core_rd(4'd6, s); check("R1 status", s, 16'h0);
        core_rd(4'd7, s); check("R1 control", s, 16'h0);
        core_rd(4'd8, s); check("R1 mask", s, 16'h0);
        for (int i = 0; i < 6; i++) begin
            core_rd(4'(i), s); check("R1 mailbox", s, 16'h0);
        end

        // all strap combinations over all mailboxes
        for (int combo = 0; combo < 8; combo++) begin
            s_byte = combo[0]; s_rwds = combo[1]; s_mux = combo[2];
            tw = $sformatf("%s%s%s", s_byte ? "R7 " : "R2 ", s_rwds ? "R9 " : "", s_mux ? "R10 " : "");
            tr = $sformatf("%s%s%s", s_byte ? "R8 " : "R3 ", s_rwds ? "R9 " : "", s_mux ? "R10 " : "");
            wait_clk(4);
            core_wr(4'd7, 16'h0006);
            core_wr(4'd8, 16'h3F3F);
            for (int i = 0; i < 6; i++) begin
                v = 16'(((combo * 6 + i + 1) * 40503) ^ 23130);
                w0 = cnt_w;
                host_xfer(1'b1, 3'(i), v, tw, q);
                check({"R5 write irq count ", tw}, 16'(cnt_w - w0), 16'd1);
                core_rd(4'd6, s); check({tw, "write flag"}, s, 16'(1 << i));
                core_rd(4'(i), s); check({tw, "write data"}, s, v);
                core_rd(4'd6, s); check("R4 core read clears write flag", s, 16'h0);
                core_wr(4'(i), ~v);
                r0 = cnt_r;
                host_xfer(1'b0, 3'(i), 16'h0, tr, q);
                check({tr, "read data"}, q, ~v);
                check({"R6 read irq count ", tr}, 16'(cnt_r - r0), 16'd1);
                core_rd(4'd6, s); check({tr, "read flag"}, s, 16'(1 << (8 + i)));
                core_wr(4'(i), v);
                core_rd(4'd6, s); check("R4 core write clears read flag", s, 16'h0);
            end
        end

        // byte mode partial transfers
        s_byte = 1; s_rwds = 0; s_mux = 0;
        wait_clk(4);
        w0 = cnt_w;
        host_set_addr(3'd3);
        host_beat(1'b1, 16'hFF34, q);
        core_rd(4'd6, s); check("R7 no flag after low byte", s, 16'h0);
        check("R7 no irq after low byte", 16'(cnt_w - w0), 16'd0);
        host_beat(1'b1, 16'hEE12, q);
        core_rd(4'd6, s); check("R7 flag after high byte", s, 16'h0008);
        check("R7 irq after high byte", 16'(cnt_w - w0), 16'd1);
        core_rd(4'd3, s); check("R7 assembled word", s, 16'h1234);
        core_wr(4'd3, 16'hBEEF);
        host_beat(1'b0, 16'h0, q);
        check("R8 low byte first", q, 16'h00EF);
        core_rd(4'd6, s); check("R8 no flag after low byte", s, 16'h0);
        host_beat(1'b0, 16'h0, q);
        check("R8 high byte second", q, 16'h00BE);
        core_rd(4'd6, s); check("R8 flag after high byte", s, 16'h0800);
        core_wr(4'd3, 16'h0);

        // mask and enable sweep, word mode
        s_byte = 0;
        wait_clk(4);
        for (int m = 0; m < 4; m++) begin
            core_wr(4'd7, m[0] ? 16'h0002 : 16'h0000);
            core_wr(4'd8, m[1] ? 16'h0004 : 16'h003B);
            w0 = cnt_w;
            host_xfer(1'b1, 3'd2, 16'(m + 16'h0100), "R5", q);
            check("R5 irq gated by mask and enable", 16'(cnt_w - w0), (m == 3) ? 16'd1 : 16'd0);
            core_rd(4'd6, s); check("R5 flag set regardless of mask", s, 16'h0004);
            core_rd(4'd2, s);
            core_wr(4'd7, m[0] ? 16'h0004 : 16'h0000);
            core_wr(4'd8, m[1] ? 16'h0400 : 16'h3B00);
            r0 = cnt_r;
            host_xfer(1'b0, 3'd2, 16'h0, "R6", q);
            check("R6 irq gated by mask and enable", 16'(cnt_r - r0), (m == 3) ? 16'd1 : 16'd0);
            core_rd(4'd6, s); check("R6 flag set regardless of mask", s, 16'h0400);
            core_wr(4'd2, 16'h0);
        end

        // status address is read-only from the host
        core_wr(4'd7, 16'h0006);
        core_wr(4'd8, 16'h3F3F);
        core_wr(4'd1, 16'h5555);
        w0 = cnt_w;
        host_xfer(1'b1, 3'd6, 16'hFFFF, "R12", q);
        check("R12 no irq on status write", 16'(cnt_w - w0), 16'd0);
        core_rd(4'd6, s); check("R12 status unchanged", s, 16'h0);
        core_rd(4'd1, s); check("R12 mailbox unchanged", s, 16'h5555);
        host_xfer(1'b1, 3'd1, 16'h2222, "R12", q);
        host_xfer(1'b0, 3'd6, 16'h0, "R12", q);
        check("R12 host reads status", q, 16'h0002);
        core_rd(4'd1, s);

        // soft reset
        core_wr(4'd4, 16'h1234);
        host_xfer(1'b1, 3'd0, 16'hAAAA, "R11", q);
        host_xfer(1'b1, 3'd7, 16'hFFFE, "R11", q);
        core_rd(4'd7, s); check("R11 bit0 clear does nothing (ctl)", s, 16'h0006);
        core_rd(4'd6, s); check("R11 bit0 clear does nothing (status)", s, 16'h0001);
        host_xfer(1'b1, 3'd7, 16'h0001, "R11", q);
        core_rd(4'd6, s); check("R11 host reset clears status", s, 16'h0);
        core_rd(4'd4, s); check("R11 host reset clears mailbox", s, 16'h0);
        core_rd(4'd0, s); check("R11 host reset clears mailbox", s, 16'h0);
        core_rd(4'd7, s); check("R11 enables kept, bit reads 0", s, 16'h0006);
        core_rd(4'd8, s); check("R11 mask kept", s, 16'h3F3F);
        host_xfer(1'b1, 3'd5, 16'h7777, "R11", q);
        core_wr(4'd7, 16'h0007);
        wait_clk(2);
        core_rd(4'd5, s); check("R11 core reset clears mailbox", s, 16'h0);
        core_rd(4'd6, s); check("R11 core reset clears status", s, 16'h0);
        core_rd(4'd7, s); check("R11 core reset bit reads 0", s, 16'h0006);
        s_byte = 1;
        wait_clk(4);
        host_set_addr(3'd1);
        host_beat(1'b1, 16'h0011, q);
        core_wr(4'd7, 16'h0007);
        wait_clk(2);
        host_xfer(1'b1, 3'd1, 16'h9ABC, "R11", q);
        core_rd(4'd1, s); check("R11 reset clears byte phase", s, 16'h9ABC);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule